// File: doc/BRIEF.md
# Circular Capture Pointer with Interrupt Pacing

This block steers one capture stream into a circular region of delay memory. The host programs where the region starts, how many sample frames it holds, how many frames pass between two interrupts, how many channels each frame carries, and a trigger level. On every sample tick while the stream runs, the block issues one write address per channel, on consecutive cycles. When the last channel of the frame has been written, it advances the ring pointer and the interrupt countdown.

The ring pointer and the interrupt countdown are two separate counters. The pointer wraps to zero at the buffer size. The countdown is reloaded from the period each time it expires, so interrupts can fall anywhere relative to the wrap. The running status is a separate output from the trigger. It turns on at a sample tick and turns off only between frames, so a frame is never cut short. The host can also clear the pointer or preset the countdown directly.

Top module: `ring_capture_ptr`

## Requirements
- R1: After a synchronous active-low reset, running, cur_ptr, cur_cnt, irq and wr_en are all zero.
- R2: running goes high on the clock edge that samples tick with trigger high and cfg_chans nonzero. The tick that raises running produces no write. While cfg_chans is zero, running stays low and ticks produce no writes.
- R3: A tick sampled while running is high, no frame is in progress, trigger is high and cfg_chans is nonzero starts a frame. The frame holds wr_en high for n consecutive cycles, starting the cycle after the tick, with wr_chan counting 0, 1, ..., n-1. Here n is the channel count in effect at the tick.
- R4: During a frame, wr_addr = (cfg_start + cur_ptr * n + wr_chan) mod 2^ADDR_W. This gives interleaved frames.
- R5: In the cycle after a frame's last write, cur_ptr becomes cur_ptr+1. If cur_ptr+1 >= cfg_size it becomes 0 instead. A cfg_size of 0 therefore holds the pointer at 0.
- R6: The same frame end decrements cur_cnt. If cur_cnt was 0 or 1, irq is high for exactly that one cycle and cur_cnt reloads from cfg_period.
- R7: After trigger goes low, or cfg_chans becomes zero, running falls on the next edge at which no frame is in progress. A frame already started completes all its writes first. No write occurs while running is low.
- R8: A ptr_clr pulse sets cur_ptr to 0 on the next edge. A cnt_preset pulse loads cur_ptr's companion countdown cur_cnt with cnt_preset_val on the next edge.
- R9: Ticks that arrive while a frame is in progress are ignored and produce no extra frame.
- R10: A cfg_chans value above MAX_CH is treated as MAX_CH channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | ADDR_W | Region start in delay memory, in samples |
| cfg_size | input | PTR_W | Ring length in frames |
| cfg_period | input | CNT_W | Frames between two interrupts |
| cfg_chans | input | CH_W | Channels per frame, 0 removes the stream |
| trigger | input | 1 | Host start request (level) |
| ptr_clr | input | 1 | Host pulse: clear the ring pointer |
| cnt_preset | input | 1 | Host pulse: load the countdown |
| cnt_preset_val | input | CNT_W | Value loaded by cnt_preset |
| tick | input | 1 | Sample tick, one cycle wide |
| running | output | 1 | Stream is running |
| cur_ptr | output | PTR_W | Current ring pointer in frames |
| cur_cnt | output | CNT_W | Frames remaining to next interrupt |
| irq | output | 1 | One-cycle interrupt pulse |
| wr_en | output | 1 | Delay-memory write strobe |
| wr_chan | output | CH_W | Channel being written |
| wr_addr | output | ADDR_W | Delay-memory write address |

## Verification
The hardest situations to reach are the ones where host actions land in the middle of a frame. One is a second tick arriving during the channel walk. Another is the trigger being withdrawn after a frame has begun. The stimulus places these exactly, by raising tick or dropping trigger on a chosen write cycle of a multi-channel frame. It then confirms that the frame still completes, that no extra frame appears, and that running falls only afterwards. Randomized reconfiguration makes the buffer shrink below the current pointer, places the region near the top of the address space, and lets the countdown and wrap boundaries coincide.

// File: rtl/ring_cap_pkg.sv
// Shared types and helpers for the circular capture pointer.
package ring_cap_pkg;

    // Run status of the stream
    typedef enum logic {
        RUN_OFF = 1'b0,
        RUN_ON  = 1'b1
    } run_state_e;

    // Saturate a requested count at a limit
    function automatic int unsigned clamp_count(input int unsigned req, input int unsigned lim);
        return (req > lim) ? lim : req;
    endfunction

endpackage

// File: rtl/cap_run_ctl.sv
// Run-state control.
// Turns running on at a sample tick once the host trigger is set and the
// stream has channels. Turns it off between frames once the trigger is
// withdrawn or the channel count is zero.
// Assumes: tick is a single-cycle strobe; busy is high for a whole frame.
module cap_run_ctl
    import ring_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic trigger,
    input  logic chans_nz,
    input  logic busy,
    output logic running
);

    run_state_e state_q;

    // Advance the run state: start at a tick, stop only when no frame is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RUN_OFF;
        end else begin
            case (state_q)
                RUN_OFF: if (tick && trigger && chans_nz) state_q <= RUN_ON;
                RUN_ON:  if (!busy && (!trigger || !chans_nz)) state_q <= RUN_OFF;
                default: state_q <= RUN_OFF;
            endcase
        end
    end

    assign running = (state_q == RUN_ON);

endmodule

// File: rtl/cap_chan_seq.sv
// Channel walker.
// On a start strobe it latches the channel count and steps through
// channels 0..n-1, one per cycle. It flags the last channel so the pointer
// logic can advance. While a walk is in progress, start strobes are ignored.
// Assumes: chans_in is at least 1 whenever go is high.
module cap_chan_seq #(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [CH_W-1:0] chans_in,
    output logic            busy,
    output logic [CH_W-1:0] chan,
    output logic [CH_W-1:0] n_lat,
    output logic            last
);

    // Last channel of the current frame
    assign last = busy && (chan == n_lat - 1'b1);

    // Walk the channels of one frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            chan  <= '0;
            n_lat <= '0;
        end else if (!busy) begin
            if (go) begin
                busy  <= 1'b1;
                chan  <= '0;
                n_lat <= chans_in;
            end
        end else if (last) begin
            busy <= 1'b0;
            chan <= '0;
        end else begin
            chan <= chan + 1'b1;
        end
    end

endmodule

// File: rtl/cap_ring_ptr.sv
// Ring pointer and interrupt countdown.
// At each frame end the pointer steps with a wrap at the buffer size, and
// the countdown steps down. When the countdown expires, it reloads from the
// period and a one-cycle interrupt is raised. Host clear and preset take
// precedence over the frame-end update.
// Assumes: step is high for one cycle per frame.
module cap_ring_ptr #(
    parameter int PTR_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             ptr_clr,
    input  logic             cnt_preset,
    input  logic [CNT_W-1:0] cnt_preset_val,
    input  logic [PTR_W-1:0] cfg_size,
    input  logic [CNT_W-1:0] cfg_period,
    output logic [PTR_W-1:0] ptr,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);

    logic [PTR_W:0] ptr_inc;
    logic           wrap;
    logic           expire;

    assign ptr_inc = {1'b0, ptr} + 1'b1;
    assign wrap    = ptr_inc >= {1'b0, cfg_size};
    assign expire  = (cnt <= CNT_W'(1));

    // Ring pointer: host clear, else step with wrap
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (ptr_clr) ptr <= '0;
        else if (step)    ptr <= wrap ? '0 : ptr_inc[PTR_W-1:0];
    end

    // Countdown: host preset, else decrement or reload on expiry
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt_preset) cnt <= cnt_preset_val;
        else if (step)       cnt <= expire ? cfg_period : cnt - 1'b1;
    end

    // Interrupt pulse for one cycle after an expiring frame
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= step && expire;
    end

endmodule

// File: rtl/ring_capture_ptr.sv
// Circular capture pointer with interrupt pacing (top).
// Joins the run control, the channel walker and the pointer/countdown, and
// forms the interleaved write address start + ptr*n + chan.
// Assumes: ticks are spaced at least MAX_CH+1 cycles apart for full rate;
// configuration changes only between frames.
module ring_capture_ptr
    import ring_cap_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int PTR_W  = 16,
    parameter int CNT_W  = 16,
    parameter int MAX_CH = 8,
    localparam int CH_W  = $clog2(MAX_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [PTR_W-1:0]  cfg_size,
    input  logic [CNT_W-1:0]  cfg_period,
    input  logic [CH_W-1:0]   cfg_chans,
    input  logic              trigger,
    input  logic              ptr_clr,
    input  logic              cnt_preset,
    input  logic [CNT_W-1:0]  cnt_preset_val,
    input  logic              tick,
    output logic              running,
    output logic [PTR_W-1:0]  cur_ptr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              irq,
    output logic              wr_en,
    output logic [CH_W-1:0]   wr_chan,
    output logic [ADDR_W-1:0] wr_addr
);

    logic            chans_nz;
    logic [CH_W-1:0] chans_eff;
    logic            busy;
    logic            last;
    logic            frame_go;
    logic [CH_W-1:0] n_lat;

    assign chans_nz  = (cfg_chans != '0);
    assign chans_eff = CH_W'(clamp_count(32'(cfg_chans), MAX_CH));
    assign frame_go  = tick && running && !busy && trigger && chans_nz;

    cap_run_ctl u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .trigger  (trigger),
        .chans_nz (chans_nz),
        .busy     (busy),
        .running  (running)
    );

    cap_chan_seq #(.CH_W(CH_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (frame_go),
        .chans_in (chans_eff),
        .busy     (busy),
        .chan     (wr_chan),
        .n_lat    (n_lat),
        .last     (last)
    );

    cap_ring_ptr #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
        .clk            (clk),
        .rst_n          (rst_n),
        .step           (last),
        .ptr_clr        (ptr_clr),
        .cnt_preset     (cnt_preset),
        .cnt_preset_val (cnt_preset_val),
        .cfg_size       (cfg_size),
        .cfg_period     (cfg_period),
        .ptr            (cur_ptr),
        .cnt            (cur_cnt),
        .irq            (irq)
    );

    // Interleaved address: frame base plus channel offset, modulo 2^ADDR_W
    always_comb begin
        wr_addr = cfg_start + ADDR_W'(cur_ptr) * ADDR_W'(n_lat) + ADDR_W'(wr_chan);
    end

    assign wr_en = busy;

endmodule

// File: rtl/ring_capture_ptr_chk.sv
// Property checker for the circular capture pointer, bound to the top.
module ring_capture_ptr_chk #(
    parameter int PTR_W = 16,
    parameter int CH_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             wr_en,
    input logic [CH_W-1:0]  wr_chan,
    input logic             irq,
    input logic [PTR_W-1:0] cur_ptr,
    input logic             ptr_clr
);

    // R7
    write_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> running);

    // R3
    first_chan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> (wr_chan == '0));

    // R3
    chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_chan == $past(wr_chan) + 1'b1));

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6
    irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(wr_en));

    // R5
    ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_ptr != $past(cur_ptr)) && !$past(ptr_clr))
            |-> ((cur_ptr == $past(cur_ptr) + 1'b1) || (cur_ptr == '0)));

endmodule

bind ring_capture_ptr ring_capture_ptr_chk #(.PTR_W(PTR_W), .CH_W(CH_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (running),
    .wr_en   (wr_en),
    .wr_chan (wr_chan),
    .irq     (irq),
    .cur_ptr (cur_ptr),
    .ptr_clr (ptr_clr)
);

// File: tb/ring_capture_ptr_tb.sv
// Self-checking bench for the circular capture pointer.
module ring_capture_ptr_tb_top;

    localparam int ADDR_W = 20;
    localparam int PTR_W  = 16;
    localparam int CNT_W  = 16;
    localparam int MAX_CH = 8;
    localparam int CH_W   = $clog2(MAX_CH + 1);
    localparam int CLK_PERIOD = 10;
    localparam longint AMASK = (64'd1 << ADDR_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] cfg_start;
    logic [PTR_W-1:0]  cfg_size;
    logic [CNT_W-1:0]  cfg_period;
    logic [CH_W-1:0]   cfg_chans;
    logic              trigger, ptr_clr, cnt_preset, tick;
    logic [CNT_W-1:0]  cnt_preset_val;
    logic              running, irq, wr_en;
    logic [PTR_W-1:0]  cur_ptr;
    logic [CNT_W-1:0]  cur_cnt;
    logic [CH_W-1:0]   wr_chan;
    logic [ADDR_W-1:0] wr_addr;

    int checks = 0;
    int failures = 0;
    longint m_ptr = 0;
    longint m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_capture_ptr #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .CNT_W(CNT_W), .MAX_CH(MAX_CH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_size(cfg_size),
        .cfg_period(cfg_period), .cfg_chans(cfg_chans), .trigger(trigger),
        .ptr_clr(ptr_clr), .cnt_preset(cnt_preset), .cnt_preset_val(cnt_preset_val),
        .tick(tick), .running(running), .cur_ptr(cur_ptr), .cur_cnt(cur_cnt),
        .irq(irq), .wr_en(wr_en), .wr_chan(wr_chan), .wr_addr(wr_addr)
    );

    function automatic longint f_chans(input longint req);
        return (req > MAX_CH) ? MAX_CH : req;
    endfunction

    function automatic longint f_next_ptr(input longint p, input longint size);
        return (p + 1 >= size) ? 0 : p + 1;
    endfunction

    function automatic longint f_addr(input longint start, input longint p, input longint n, input longint c);
        return (start + p * n + c) & AMASK;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One full frame with optional mid-frame tick (R9) or trigger drop (R7)
    task automatic run_frame(input bit extra_tick, input bit drop_trig);
        longint n = f_chans(cfg_chans);
        longint exp_irq;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (drop_trig) trigger = 1'b0;
        for (int c = 0; c < n; c++) begin
            chk("R3 wr_en in frame", wr_en, 1);
            chk("R3 channel order", wr_chan, c);
            chk("R4 write address", wr_addr, f_addr(cfg_start, m_ptr, n, c));
            tick = extra_tick && (c == 1);
            @(negedge clk);
        end
        tick = 1'b0;
        exp_irq = (m_cnt <= 1) ? 1 : 0;
        m_cnt = exp_irq ? longint'(cfg_period) : m_cnt - 1;
        m_ptr = f_next_ptr(m_ptr, cfg_size);
        chk("R6 irq at frame end", irq, exp_irq);
        chk("R5 pointer after frame", cur_ptr, m_ptr);
        chk("R6 countdown after frame", cur_cnt, m_cnt);
        chk("R7 wr_en low after frame", wr_en, 0);
        @(negedge clk);
        chk("R6 irq one cycle", irq, 0);
        chk("R9 no extra frame", wr_en, 0);
        if (drop_trig) chk("R7 running falls after frame", running, 0);
    endtask

    // Tick that should raise running without writing (R2)
    task automatic arm();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R2 running rises at tick", running, 1);
        chk("R2 no write on arming tick", wr_en, 0);
        @(negedge clk);
        chk("R2 still no write", wr_en, 0);
    endtask

    task automatic preset(input longint v);
        cnt_preset = 1'b1;
        cnt_preset_val = CNT_W'(v);
        @(negedge clk);
        cnt_preset = 1'b0;
        m_cnt = v;
        chk("R8 countdown preset", cur_cnt, v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        rst_n = 1'b0; trigger = 1'b0; ptr_clr = 1'b0; cnt_preset = 1'b0; tick = 1'b0;
        cnt_preset_val = '0; cfg_start = 20'h100; cfg_size = 5; cfg_period = 3; cfg_chans = 2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 running reset", running, 0);
        chk("R1 ptr reset", cur_ptr, 0);
        chk("R1 cnt reset", cur_cnt, 0);
        chk("R1 irq reset", irq, 0);
        chk("R1 wr_en reset", wr_en, 0);

        // Tick without trigger: nothing happens (R2)
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R2 no run without trigger", running, 0);

        preset(3);
        trigger = 1'b1;
        @(negedge clk);
        chk("R2 running waits for tick", running, 0);
        arm();
        for (int i = 0; i < 7; i++) run_frame(0, 0);

        // R9: tick during a 4-channel frame
        cfg_chans = 4;
        run_frame(1, 0);
        repeat (3) @(negedge clk);
        chk("R9 idle after ignored tick", wr_en, 0);
        chk("R9 pointer stepped once", cur_ptr, m_ptr);

        // R10: oversize channel count
        cfg_chans = 13;
        run_frame(0, 0);
        run_frame(1, 0);

        // R4: address wraps at the top of the space
        cfg_start = 20'hFFFFD; cfg_chans = 3;
        run_frame(0, 0);
        run_frame(0, 0);

        // R8: pointer clear while idle
        ptr_clr = 1'b1; @(negedge clk); ptr_clr = 1'b0;
        m_ptr = 0;
        chk("R8 pointer cleared", cur_ptr, 0);
        run_frame(0, 0);

        // R5: size zero pins the pointer
        cfg_size = 0;
        run_frame(0, 0);
        run_frame(0, 0);
        chk("R5 size zero holds pointer", cur_ptr, 0);
        cfg_size = 6;

        // R7: trigger withdrawn mid-frame, frame completes
        run_frame(0, 1);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        repeat (4) begin
            chk("R7 no write after stop", wr_en, 0);
            @(negedge clk);
        end
        chk("R7 stays stopped", running, 0);
        chk("R7 pointer unchanged when stopped", cur_ptr, m_ptr);

        // R2/R7: zero channels removes the stream
        trigger = 1'b1; cfg_chans = 0;
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R2 no run with zero channels", running, 0);
        @(negedge clk);
        chk("R2 no write with zero channels", wr_en, 0);
        cfg_chans = 2;
        arm();
        run_frame(0, 0);
        cfg_chans = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 running falls at zero channels", running, 0);
        cfg_chans = 3;
        arm();

        // Random reconfiguration and frames
        for (int f = 0; f < 160; f++) begin
            if (f % 12 == 0) begin
                cfg_start  = ADDR_W'($urandom);
                cfg_size   = PTR_W'($urandom_range(1, 9));
                cfg_period = CNT_W'($urandom_range(1, 6));
                cfg_chans  = CH_W'($urandom_range(1, 11));
                if ($urandom_range(0, 1) == 1) preset($urandom_range(0, 5));
            end
            run_frame($urandom_range(0, 3) == 0 && f_chans(cfg_chans) >= 2, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule